// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers six interrupt levels, numbered 0 to 5, and hands one of them at a time to a processor. Three external pins feed levels 0, 1 and 2. Each pin passes through a synchronizer and an edge detector. Two comparator events are merged into levels 0 and 2. Level 3 is driven by the 16-bit timer and level 4 by the 8-bit timer. Level 5 is driven by either the low-battery detector or timer 1.

Incoming events collect in a pending latch. A sample strobe from the processor's fetch sequencer moves them into a software-visible request register. Each level has its own mask bit, and a master enable gates them all. A configurable priority encoder picks the winning level.

A grant is a one-cycle pulse with the winning level's index and the byte address of its 16-bit vector. The vector table fills the bottom 12 bytes of program space. The grant clears only the winning request bit and shuts the master enable. Software reaches the request, mask and priority registers through a simple select/write port. Writing a request bit raises a software interrupt, which is handled like any hardware request.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, the request, mask and priority registers read 0, and `grant_o` is low.
- R2: An external pin change applied before clock edge k reaches the pending latch at edge k+2. It enters the request register at the first edge with `sample_i` high that is k+2 or later. A strobe at edge k+1 does not capture it.
- R3: Pin 1 sets request bit 1 on a falling edge only. Request bit 6 selects the active edge of pin 0 (1 = rising, 0 = falling). Request bit 7 does the same for pin 2. An edge of the inactive polarity sets nothing.
- R4: A pulse high at a clock edge sets a pending bit: `cmp_evt_i[0]` sets level 0, `cmp_evt_i[1]` level 2, `t16_evt_i` level 3 and `t8_evt_i` level 4.
- R5: When `lvd_en_i` is 1, only `lowbat_evt_i` raises level 5. When it is 0, only `t1_evt_i` does.
- R6: Pending events reach the request register only at an edge with `sample_i` high, and that strobe empties the pending latch. An event arriving at the same edge as the strobe is captured by that strobe.
- R7: Writing the request register (select 0) loads all 8 bits. A request bit set this way is granted like a hardware request.
- R8: Mask bit 7 is the master enable. `ei_i` sets it and `di_i` clears it. A register write of 1 to it takes effect only after the first `ei_i` since reset.
- R9: If the master enable is set and a request bit and its mask bit are both 1 at edge n, `grant_o` is high for exactly the cycle after edge n. `grant_idx_o` then holds the level and `vec_addr_o` holds twice the level. That edge clears only the winning request bit and clears the master enable.
- R10: Priority register bits 2:0 give the first level searched, where 6 or 7 means level 0. Bit 3 gives the direction: 0 searches upward and 1 downward, wrapping modulo 6. The first pending, unmasked level found wins.
- R11: No grant is issued while the master enable is 0, or while no level has both its request and mask bits set.
- R12: `reg_sel_i` selects 0 = request, 1 = mask, 2 = priority, 3 = reads 0. `reg_rdata_o` shows the selected register combinationally. Mask bit 6 and priority bits 7:4 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | 3 | External request pins for levels 0, 1, 2 |
| cmp_evt_i | input | 2 | Comparator event pulses (bit 0 to level 0, bit 1 to level 2) |
| t16_evt_i | input | 1 | 16-bit timer event pulse (level 3) |
| t8_evt_i | input | 1 | 8-bit timer event pulse (level 4) |
| t1_evt_i | input | 1 | Timer 1 event pulse (level 5 when detector disabled) |
| lowbat_evt_i | input | 1 | Low-battery event pulse (level 5 when detector enabled) |
| lvd_en_i | input | 1 | Selects the low-battery detector as the level-5 source |
| sample_i | input | 1 | Strobe that moves pending events into the request register |
| ei_i | input | 1 | Enable-interrupts strobe |
| di_i | input | 1 | Disable-interrupts strobe |
| reg_we_i | input | 1 | Register write enable |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Selected register contents |
| grant_o | output | 1 | One-cycle grant pulse |
| grant_idx_o | output | 3 | Granted level |
| vec_addr_o | output | 16 | Byte address of the granted vector |

## Verification
Pins are the slowest path. A pin change set up before edge k appears in the request register only after a strobe at edge k+2 or later. A read at k+2 without a strobe therefore still shows zero. Internal pulses and strobes act at the very next edge, and register reads are combinational. A grant follows one edge after its enabling state, so a grant after an EI strobe is due two edges after that strobe.

The bench's behavioural model replays pin history in a queue with exactly this lag. It is compared at each falling clock edge, after the design's registers have settled. Directed reads are placed with the same edge counts.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int DEF_LVL   = 6;
  localparam int DEF_EXT   = 3;
  localparam int DEF_SYNC  = 2;
  localparam int DEF_DW    = 8;
  localparam int DEF_VEC_W = 16;

  typedef enum logic [1:0] {
    SEL_REQ  = 2'd0,
    SEL_MASK = 2'd1,
    SEL_PRIO = 2'd2,
    SEL_NONE = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  input  logic rise_i,
  output logic edge_o
);
  logic [SYNC_DEPTH:0] stage_q;
  logic cur, old;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stage_q <= '0;
    else         stage_q <= {stage_q[SYNC_DEPTH-1:0], pin_i};
  end

  assign cur    = stage_q[SYNC_DEPTH-1];
  assign old    = stage_q[SYNC_DEPTH];
  assign edge_o = rise_i ? (cur & ~old) : (~cur & old);
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NUM_LVL = 6,
  parameter int IDX_W   = 3,
  localparam int CFG_W  = IDX_W + 1
) (
  input  logic [NUM_LVL-1:0] pend_i,
  input  logic [CFG_W-1:0]   cfg_i,
  output logic               any_o,
  output logic [IDX_W-1:0]   idx_o
);
  int top;
  int cand;

  // walk from lowest to highest rank so the highest-ranked hit lands last
  always_comb begin
    top = int'(cfg_i[IDX_W-1:0]);
    if (top >= NUM_LVL) top = 0;
    any_o = 1'b0;
    idx_o = '0;
    cand  = 0;
    for (int k = NUM_LVL - 1; k >= 0; k--) begin
      cand = cfg_i[IDX_W] ? (top + NUM_LVL - k) % NUM_LVL : (top + k) % NUM_LVL;
      if (pend_i[cand[IDX_W-1:0]]) begin
        any_o = 1'b1;
        idx_o = cand[IDX_W-1:0];
      end
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_LVL    = DEF_LVL,
  parameter int NUM_EXT    = DEF_EXT,
  parameter int SYNC_DEPTH = DEF_SYNC,
  parameter int DATA_W     = DEF_DW,
  parameter int VEC_W      = DEF_VEC_W,
  localparam int IDX_W     = $clog2(NUM_LVL),
  localparam int PRIO_W    = IDX_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EXT-1:0] ext_pin_i,
  input  logic [1:0]         cmp_evt_i,
  input  logic               t16_evt_i,
  input  logic               t8_evt_i,
  input  logic               t1_evt_i,
  input  logic               lowbat_evt_i,
  input  logic               lvd_en_i,
  input  logic               sample_i,
  input  logic               ei_i,
  input  logic               di_i,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_sel_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               grant_o,
  output logic [IDX_W-1:0]   grant_idx_o,
  output logic [VEC_W-1:0]   vec_addr_o
);
  localparam int MASTER_BIT = DATA_W - 1;
  localparam int POL0_BIT   = DATA_W - 2;
  localparam int POL2_BIT   = DATA_W - 1;

  logic [DATA_W-1:0]  req_q, req_d, mask_q, mask_d;
  logic [PRIO_W-1:0]  prio_q, prio_d;
  logic               armed_q;
  logic [NUM_LVL-1:0] pend_q, pend_d, evt, raw, enabled;
  logic [NUM_EXT-1:0] ext_edge, rise_sel;
  logic               any_hit, fire;
  logic [IDX_W-1:0]   win, idx_q;
  logic               grant_q;
  logic               wr_req, wr_mask, wr_prio;

  // pin 1 is fixed falling; pins 0 and 2 take polarity from request bits
  assign rise_sel = {req_q[POL2_BIT], 1'b0, req_q[POL0_BIT]};

  for (genvar j = 0; j < NUM_EXT; j++) begin : g_ext
    irq_edge_det #(.SYNC_DEPTH(SYNC_DEPTH)) u_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (ext_pin_i[j]),
      .rise_i (rise_sel[j]),
      .edge_o (ext_edge[j])
    );
  end

  assign evt = {lvd_en_i ? lowbat_evt_i : t1_evt_i,
                t8_evt_i,
                t16_evt_i,
                ext_edge[2] | cmp_evt_i[1],
                ext_edge[1],
                ext_edge[0] | cmp_evt_i[0]};
  assign raw     = pend_q | evt;
  assign enabled = req_q[NUM_LVL-1:0] & mask_q[NUM_LVL-1:0];

  irq_prio_sel #(.NUM_LVL(NUM_LVL), .IDX_W(IDX_W)) u_prio (
    .pend_i (enabled),
    .cfg_i  (prio_q),
    .any_o  (any_hit),
    .idx_o  (win)
  );

  assign fire    = mask_q[MASTER_BIT] & any_hit;
  assign wr_req  = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_REQ);
  assign wr_mask = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_MASK);
  assign wr_prio = reg_we_i && (reg_sel_e'(reg_sel_i) == SEL_PRIO);

  always_comb begin
    req_d = wr_req ? reg_wdata_i : req_q;
    if (sample_i) req_d[NUM_LVL-1:0] = req_d[NUM_LVL-1:0] | raw;
    if (fire) req_d[win] = 1'b0;
    pend_d = sample_i ? '0 : raw;

    mask_d = mask_q;
    if (wr_mask) begin
      mask_d                 = '0;
      mask_d[NUM_LVL-1:0]    = reg_wdata_i[NUM_LVL-1:0];
      mask_d[MASTER_BIT]     = reg_wdata_i[MASTER_BIT] & armed_q;
    end
    if (ei_i) mask_d[MASTER_BIT] = 1'b1;
    if (di_i) mask_d[MASTER_BIT] = 1'b0;
    if (fire) mask_d[MASTER_BIT] = 1'b0;

    prio_d = wr_prio ? reg_wdata_i[PRIO_W-1:0] : prio_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      mask_q  <= '0;
      prio_q  <= '0;
      pend_q  <= '0;
      armed_q <= 1'b0;
      grant_q <= 1'b0;
      idx_q   <= '0;
    end else begin
      req_q   <= req_d;
      mask_q  <= mask_d;
      prio_q  <= prio_d;
      pend_q  <= pend_d;
      armed_q <= armed_q | ei_i;
      grant_q <= fire;
      if (fire) idx_q <= win;
    end
  end

  always_comb begin
    unique case (reg_sel_e'(reg_sel_i))
      SEL_REQ:  reg_rdata_o = req_q;
      SEL_MASK: reg_rdata_o = mask_q;
      SEL_PRIO: reg_rdata_o = {{(DATA_W-PRIO_W){1'b0}}, prio_q};
      default:  reg_rdata_o = '0;
    endcase
  end

  assign grant_o     = grant_q;
  assign grant_idx_o = idx_q;
  assign vec_addr_o  = {{(VEC_W-IDX_W-1){1'b0}}, idx_q, 1'b0};
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int NUM_LVL = 6,
  parameter int DATA_W  = 8,
  parameter int IDX_W   = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sample_i,
  input logic              reg_we_i,
  input logic              grant_o,
  input logic [IDX_W-1:0]  grant_idx_o,
  input logic [DATA_W-1:0] req_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              armed_q
);
  // R9
  grant_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |=> !grant_o);

  // R9
  grant_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> !mask_q[DATA_W-1]);

  // R11
  grant_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> ($past(mask_q[DATA_W-1]) &&
                 (($past(req_q[NUM_LVL-1:0]) & $past(mask_q[NUM_LVL-1:0])) != '0)));

  // R8
  master_armed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mask_q[DATA_W-1] |-> armed_q);

  // R6
  req_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!$past(sample_i) && !$past(reg_we_i)) |->
      ((req_q[NUM_LVL-1:0] & ~$past(req_q[NUM_LVL-1:0])) == '0));

  // R10
  grant_idx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_o |-> (int'(grant_idx_o) < NUM_LVL));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(
  .NUM_LVL (NUM_LVL),
  .DATA_W  (DATA_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .sample_i    (sample_i),
  .reg_we_i    (reg_we_i),
  .grant_o     (grant_o),
  .grant_idx_o (grant_idx_o),
  .req_q       (req_q),
  .mask_q      (mask_q),
  .armed_q     (armed_q)
);

// File: tb/sim_irq_vec_ctrl.sv
module sim_irq_vec_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  ext_pin = '0;
  logic [1:0]  cmp_evt = '0;
  logic        t16 = 0, t8 = 0, t1 = 0, lowbat = 0, lvd_en = 0;
  logic        sample = 0, ei = 0, di = 0, we = 0;
  logic [1:0]  sel = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic        grant;
  logic [2:0]  gidx;
  logic [15:0] vaddr;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  irq_vec_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .ext_pin_i(ext_pin), .cmp_evt_i(cmp_evt),
    .t16_evt_i(t16), .t8_evt_i(t8), .t1_evt_i(t1), .lowbat_evt_i(lowbat),
    .lvd_en_i(lvd_en), .sample_i(sample), .ei_i(ei), .di_i(di),
    .reg_we_i(we), .reg_sel_i(sel), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .grant_o(grant), .grant_idx_o(gidx), .vec_addr_o(vaddr)
  );

  // ---------------- reference model ----------------
  int m_req = 0, m_mask = 0, m_prio = 0, m_pend = 0;
  bit m_armed = 0;
  int hist[$] = '{0, 0, 0};
  bit e_grant = 0;
  int e_idx = 0;

  function automatic int pick(int cand_set, int cfg);
    int top = cfg & 7;
    bit down = ((cfg >> 3) & 1) != 0;
    if (top > 5) top = 0;
    for (int s = 0; s < 6; s++) begin
      int lvl = down ? ((top - s + 6) % 6) : ((top + s) % 6);
      if ((cand_set >> lvl) & 1) return lvl;
    end
    return -1;
  endfunction

  function automatic bit saw_edge(int old_v, int cur_v, int pin, bit rising);
    bit o = ((old_v >> pin) & 1) != 0;
    bit c = ((cur_v >> pin) & 1) != 0;
    return rising ? (c && !o) : (!c && o);
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    int ev, rawv, nreq, nmask, w;
    bit f;
    if (!rst_n) begin
      m_req = 0; m_mask = 0; m_prio = 0; m_pend = 0; m_armed = 0;
      hist = '{0, 0, 0};
      e_grant = 0; e_idx = 0;
    end else begin
      hist.push_back(int'(ext_pin));
      ev = 0;
      if (saw_edge(hist[0], hist[1], 0, ((m_req >> 6) & 1) != 0)) ev |= 1;
      if (saw_edge(hist[0], hist[1], 1, 1'b0))                    ev |= 2;
      if (saw_edge(hist[0], hist[1], 2, ((m_req >> 7) & 1) != 0)) ev |= 4;
      void'(hist.pop_front());
      if (cmp_evt[0]) ev |= 1;
      if (cmp_evt[1]) ev |= 4;
      if (t16) ev |= 8;
      if (t8)  ev |= 16;
      if (lvd_en ? lowbat : t1) ev |= 32;
      rawv = m_pend | ev;
      w = pick(m_req & m_mask & 63, m_prio);
      f = ((m_mask >> 7) & 1) != 0 && w >= 0;
      nreq = (we && sel == 2'd0) ? int'(wdata) : m_req;
      if (sample) nreq |= rawv;
      if (f) nreq &= ~(1 << w);
      nmask = m_mask;
      if (we && sel == 2'd1) nmask = (int'(wdata) & 63) | ((wdata[7] && m_armed) ? 128 : 0);
      if (ei) nmask |= 128;
      if (di) nmask &= ~128;
      if (f)  nmask &= ~128;
      if (we && sel == 2'd2) m_prio = int'(wdata) & 15;
      m_pend  = sample ? 0 : rawv;
      m_req   = nreq;
      m_mask  = nmask;
      m_armed = m_armed | ei;
      e_grant = f;
      if (f) e_idx = w;
    end
  end

  function automatic int exp_rd();
    case (sel)
      2'd0: return m_req;
      2'd1: return m_mask;
      2'd2: return m_prio;
      default: return 0;
    endcase
  endfunction

  // ---------------- checking ----------------
  task automatic chk(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic compare();
    chk(grant == e_grant, "R9 grant pulse", int'(grant), int'(e_grant));
    if (e_grant) begin
      chk(int'(gidx) == e_idx, "R10 granted level", int'(gidx), e_idx);
      chk(int'(vaddr) == 2 * e_idx, "R9 vector address", int'(vaddr), 2 * e_idx);
    end
    chk(int'(rdata) == exp_rd(), "R12 readback", int'(rdata), exp_rd());
  endtask

  task automatic cyc();
    @(negedge clk);
    compare();
    sample = 0; ei = 0; di = 0; we = 0;
    cmp_evt = '0; t16 = 0; t8 = 0; t1 = 0; lowbat = 0;
  endtask

  task automatic settle(int n);
    for (int i = 0; i < n; i++) begin
      sample = 1;
      cyc();
    end
  endtask

  task automatic wr(int s, int d);
    we = 1; sel = 2'(s); wdata = 8'(d);
    cyc();
  endtask

  task automatic rd(int s, int exp, string tag);
    sel = 2'(s);
    cyc();
    chk(int'(rdata) == exp, tag, int'(rdata), exp);
  endtask

  task automatic grant_expect(int exp, string tag);
    ei = 1;
    cyc();
    cyc();
    chk(grant == 1'b1, tag, int'(grant), 1);
    chk(int'(gidx) == exp, tag, int'(gidx), exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;

    // R1
    rd(0, 0, "R1 request after reset");
    rd(1, 0, "R1 mask after reset");
    rd(2, 0, "R1 priority after reset");
    chk(grant == 1'b0, "R1 no grant after reset", int'(grant), 0);

    // R3 / R2 pin 1
    ext_pin = 3'b010; settle(4);
    rd(0, 0, "R3 pin1 rising ignored");
    ext_pin = 3'b000;
    cyc();
    sample = 1; cyc();
    rd(0, 0, "R2 strobe before sync ignored");
    settle(1);
    rd(0, 8'h02, "R2 pin1 falling captured");
    wr(0, 0);

    // R3 pin 0
    ext_pin = 3'b001; settle(4);
    rd(0, 0, "R3 pin0 rising ignored");
    ext_pin = 3'b000; settle(4);
    rd(0, 8'h01, "R3 pin0 falling");
    wr(0, 8'h40);
    ext_pin = 3'b001; settle(4);
    rd(0, 8'h41, "R3 pin0 rising selected");

    // R3 pin 2
    wr(0, 0);
    ext_pin = 3'b101; settle(4);
    rd(0, 0, "R3 pin2 rising ignored");
    ext_pin = 3'b001; settle(4);
    rd(0, 8'h04, "R3 pin2 falling");
    wr(0, 8'h80);
    ext_pin = 3'b101; settle(4);
    rd(0, 8'h84, "R3 pin2 rising selected");
    wr(0, 0);

    // R4
    cmp_evt = 2'b11; t16 = 1; t8 = 1; cyc();
    settle(1);
    rd(0, 8'h1D, "R4 internal sources");
    wr(0, 0);

    // R5
    lvd_en = 1; t1 = 1; cyc(); settle(1);
    rd(0, 0, "R5 timer1 blocked by detector");
    lowbat = 1; cyc(); settle(1);
    rd(0, 8'h20, "R5 low battery raises level5");
    wr(0, 0);
    lvd_en = 0; lowbat = 1; cyc(); settle(1);
    rd(0, 0, "R5 low battery ignored when disabled");
    t1 = 1; cyc(); settle(1);
    rd(0, 8'h20, "R5 timer1 raises level5");
    wr(0, 0);

    // R6
    t8 = 1; cyc();
    rd(0, 0, "R6 held until strobe");
    settle(1);
    rd(0, 8'h10, "R6 moved at strobe");
    wr(0, 0);
    settle(1);
    rd(0, 0, "R6 pending emptied by strobe");
    t16 = 1; sample = 1; cyc();
    rd(0, 8'h08, "R6 coincident event captured");
    wr(0, 0);

    // R8 before arming
    wr(1, 8'hBF);
    rd(1, 8'h3F, "R8 master write ignored before EI");

    // R7 / R11 / R9
    wr(0, 8'h08);
    for (int i = 0; i < 3; i++) begin
      cyc();
      chk(grant == 1'b0, "R11 no grant with master off", int'(grant), 0);
    end
    ei = 1; cyc();
    cyc();
    chk(grant == 1'b1, "R7 software request granted", int'(grant), 1);
    chk(int'(gidx) == 3, "R9 granted index", int'(gidx), 3);
    chk(int'(vaddr) == 6, "R9 vector address", int'(vaddr), 6);
    cyc();
    chk(grant == 1'b0, "R9 single-cycle grant", int'(grant), 0);
    rd(1, 8'h3F, "R9 master cleared by grant");
    rd(0, 0, "R9 granted bit cleared");

    // R8 after arming
    wr(1, 8'hBF);
    rd(1, 8'hBF, "R8 master write after EI");
    di = 1; cyc();
    rd(1, 8'h3F, "R8 DI clears master");

    // R9 only winner cleared
    wr(0, 8'h0A);
    grant_expect(1, "R9 lowest level wins by default");
    rd(0, 8'h08, "R9 only winner cleared");

    // R10
    wr(2, 0);    wr(0, 8'h21); grant_expect(0, "R10 default order");
    wr(2, 8'h0A); wr(0, 8'h21); grant_expect(0, "R10 descending from 2");
    wr(2, 8'h03); wr(0, 8'h21); grant_expect(5, "R10 ascending from 3");
    wr(2, 8'h09); wr(0, 8'h24); grant_expect(5, "R10 descending wrap");
    wr(2, 8'h07); wr(0, 8'h24); grant_expect(2, "R10 out-of-range top");
    wr(1, 8'h1F); wr(2, 8'h03); wr(0, 8'h24);
    grant_expect(2, "R11 masked level skipped");

    // R11
    wr(1, 8'h00); wr(0, 8'h3F);
    ei = 1; cyc(); cyc();
    chk(grant == 1'b0, "R11 nothing unmasked", int'(grant), 0);
    rd(1, 8'h80, "R11 master stays set without grant");
    di = 1; cyc();
    wr(0, 0);

    // R12
    rd(3, 0, "R12 unused select");
    wr(2, 8'hFF);
    rd(2, 8'h0F, "R12 priority width");
    wr(1, 8'h40);
    rd(1, 0, "R12 mask bit6 reads zero");
    wr(2, 0);

    // mixed traffic against the model
    for (int i = 0; i < 3000; i++) begin
      sample  = ($urandom % 2) == 0;
      ei      = ($urandom % 16) == 0;
      di      = ($urandom % 16) == 0;
      we      = ($urandom % 8) == 0;
      sel     = 2'($urandom % 4);
      wdata   = 8'($urandom);
      if (($urandom % 4) == 0) ext_pin = ext_pin ^ 3'($urandom);
      cmp_evt = 2'(($urandom % 8) == 0 ? $urandom : 0);
      t16     = ($urandom % 8) == 0;
      t8      = ($urandom % 8) == 0;
      t1      = ($urandom % 8) == 0;
      lowbat  = ($urandom % 8) == 0;
      if (($urandom % 64) == 0) lvd_en = ~lvd_en;
      cyc();
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule